// File: doc/BRIEF.md
# Flash In-System Programming Controller

This block sits between a processor's register bus and a small on-chip flash array model. Software chooses an operation by writing an operation code, a target address and, for a word program, a data word. It then writes 1 to the trigger register and polls that register until it reads 0. The controller supports word reads, word programs, page erases and reads of identification words. It also has one command that records a vector-remap page address.

Each command runs for a fixed number of clock cycles and is checked for legality when it completes. A command that is not allowed leaves the array untouched and sets a sticky fail flag. Software clears that flag by writing 1 to its bit. The control register also holds a master enable, one update enable for each of the three flash regions, and a boot-select bit that drives a pin for use at the next reset.

Top module: `isp_flash_ctrl`

## Requirements
- R1: After reset, every register reads 0: control, address, data, command, trigger and status. The boot output is 0 and every flash word reads 0xFFFF_FFFF.
- R2: The trigger register is at byte offset 0x10.
  - Writing it with bit 0 set while the controller is idle starts the command, and bit 0 reads 1 for exactly OP_CYCLES cycles before hardware clears it.
  - A trigger write with bit 0 clear starts nothing.
  - While the trigger is set, writes to the address (0x04), data (0x08) and command (0x0C) registers are ignored.
- R3: Operation code 0x00 copies the flash word at a word-aligned address into the data register.
- R4: Operation code 0x21 stores the bitwise AND of the old word and the data register, so a program can only clear bits.
- R5: Operation code 0x22 at a 512-byte-aligned address sets all 128 words of that page to 0xFFFF_FFFF and leaves other pages unchanged.
- R6: The control register is at offset 0x00. Its bits 3, 4 and 5 enable updates to the application region (from 0x0), the loader region (4 KB from 0x0010_0000) and the configuration region (from 0x0030_0000). A program or erase aimed at a region whose enable is clear fails and changes nothing.
- R7: The fail flag is control bit 6. Once set, it stays set through later successful commands until software writes 1 to bit 6.
- R8: Each of the following fails and touches neither the array nor the data register:
  - a command issued while control bit 0 (master enable) is clear;
  - an unknown operation code;
  - a misaligned address;
  - an address outside every region.
- R9: Identification reads:
  - Code 0x0B at address 0 returns 0xDA.
  - Code 0x0C at address 4 returns the device word.
  - Code 0x04 returns the unique-ID words at addresses 0x0, 0x4 and 0x8, and the chip-ID words from 0x10 upward.
  - Any other address fails.
- R10: Code 0x2E with a page-aligned address in the application or loader region stores that address, which reads back from the status register at offset 0x14. A misaligned address fails and keeps the old value.
- R11: Control bit 1 is the boot-select bit; a control value of 2 selects the loader. It reads back and drives boot_ldr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| boot_ldr_o | output | 1 | Boot-select held for the next reset (1 = loader) |

## Verification
Two situations are hard to reach from the register bus. The first is a register write arriving while a command is still in flight. The bench reaches it by starting a read and, in the next two cycles, writing a new address and an operation code before the trigger clears. Afterwards it checks that the read result and the register contents belong to the original command. The second is a protected region, which has to be shown unchanged. For this the bench disables one region's enable, issues a program or erase into a word it wrote earlier, and reads that word back through a normal read command.

// File: rtl/ispf_pkg.sv
package ispf_pkg;

    localparam logic [7:0] OP_READ  = 8'h00;
    localparam logic [7:0] OP_PROG  = 8'h21;
    localparam logic [7:0] OP_ERASE = 8'h22;
    localparam logic [7:0] OP_VMAP  = 8'h2E;
    localparam logic [7:0] OP_UID   = 8'h04;
    localparam logic [7:0] OP_CID   = 8'h0B;
    localparam logic [7:0] OP_DID   = 8'h0C;

    localparam int CB_EN    = 0;
    localparam int CB_BOOT  = 1;
    localparam int CB_APPWE = 3;
    localparam int CB_LDRWE = 4;
    localparam int CB_CFGWE = 5;
    localparam int CB_FAIL  = 6;

    localparam logic [2:0] RG_CTRL = 3'd0;
    localparam logic [2:0] RG_ADDR = 3'd1;
    localparam logic [2:0] RG_DATA = 3'd2;
    localparam logic [2:0] RG_CMD  = 3'd3;
    localparam logic [2:0] RG_TRIG = 3'd4;
    localparam logic [2:0] RG_STAT = 3'd5;

    localparam logic [31:0] LDR_BASE   = 32'h0010_0000;
    localparam logic [31:0] CFG_BASE   = 32'h0030_0000;
    localparam int          PAGE_BYTES = 512;
    localparam int          WPP        = PAGE_BYTES / 4;
    localparam logic [31:0] CID_VALUE  = 32'h0000_00DA;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_APP,
        RGN_LDR,
        RGN_CFG
    } region_e;

endpackage

// File: rtl/ispf_addr_dec.sv
module ispf_addr_dec
    import ispf_pkg::*;
#(
    parameter int APP_BYTES = 1024,
    parameter int LDR_BYTES = 4096,
    parameter int CFG_BYTES = 8,
    parameter int IDX_W     = 11
) (
    input  logic [31:0]      addr,
    output region_e          region,
    output logic [IDX_W-1:0] widx,
    output logic             word_al,
    output logic             page_al
);
    localparam logic [31:0] APP_END   = 32'(APP_BYTES);
    localparam logic [31:0] LDR_END   = LDR_BASE + 32'(LDR_BYTES);
    localparam logic [31:0] CFG_END   = CFG_BASE + 32'(CFG_BYTES);
    localparam logic [31:0] LDR_WBASE = 32'(APP_BYTES / 4);
    localparam logic [31:0] CFG_WBASE = 32'((APP_BYTES + LDR_BYTES) / 4);

    logic [31:0] off;
    logic [31:0] wbase;

    always_comb begin
        region  = RGN_NONE;
        off     = '0;
        wbase   = '0;
        word_al = (addr[1:0] == 2'b00);
        page_al = ((addr & 32'(PAGE_BYTES - 1)) == 32'd0);
        if (addr < APP_END) begin
            region = RGN_APP;
            off    = addr;
        end else if (addr >= LDR_BASE && addr < LDR_END) begin
            region = RGN_LDR;
            off    = addr - LDR_BASE;
            wbase  = LDR_WBASE;
        end else if (addr >= CFG_BASE && addr < CFG_END) begin
            region = RGN_CFG;
            off    = addr - CFG_BASE;
            wbase  = CFG_WBASE;
        end
        widx = IDX_W'((off >> 2) + wbase);
    end

endmodule

// File: rtl/ispf_id_rom.sv
module ispf_id_rom
    import ispf_pkg::*;
#(
    parameter logic [95:0]  UNIQ_ID = 96'hC3A5_1F00_7E21_9B44_0D6C_E812,
    parameter logic [127:0] CHIP_ID = 128'h4455_6677_8899_AABB_CCDD_EEFF_0011_2233,
    parameter logic [31:0]  DEV_ID  = 32'h0002_3B10
) (
    input  logic [7:0]  op,
    input  logic [31:0] addr,
    output logic        hit,
    output logic [31:0] word
);
    localparam int UID_WORDS  = 3;
    localparam int CHIP_WORDS = 4;
    localparam int CHIP_OFS   = 16;

    always_comb begin
        hit  = 1'b0;
        word = '0;
        case (op)
            OP_UID: begin
                for (int k = 0; k < UID_WORDS; k++) begin
                    if (addr == 32'(4 * k)) begin
                        hit  = 1'b1;
                        word = UNIQ_ID[32*k +: 32];
                    end
                end
                for (int k = 0; k < CHIP_WORDS; k++) begin
                    if (addr == 32'(CHIP_OFS + 4 * k)) begin
                        hit  = 1'b1;
                        word = CHIP_ID[32*k +: 32];
                    end
                end
            end
            OP_CID: begin
                hit  = (addr == 32'd0);
                word = CID_VALUE;
            end
            OP_DID: begin
                hit  = (addr == 32'd4);
                word = DEV_ID;
            end
            default: begin
                hit  = 1'b0;
                word = '0;
            end
        endcase
    end

endmodule

// File: rtl/ispf_flash_array.sv
module ispf_flash_array
    import ispf_pkg::*;
#(
    parameter int TOTAL_WORDS = 1282,
    parameter int IDX_W       = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en,
    input  logic             erase_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);
    localparam int PG_SH = $clog2(WPP);

    logic [31:0] mem_q [TOTAL_WORDS];
    logic [31:0] mem_d [TOTAL_WORDS];

    always_comb begin
        for (int w = 0; w < TOTAL_WORDS; w++) begin
            mem_d[w] = mem_q[w];
            if (erase_en && ((w / WPP) == int'(idx >> PG_SH))) begin
                mem_d[w] = '1;
            end
            if (prog_en && (32'(idx) == 32'(w))) begin
                mem_d[w] = mem_q[w] & wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < TOTAL_WORDS; w++) mem_q[w] <= '1;
        end else begin
            for (int w = 0; w < TOTAL_WORDS; w++) mem_q[w] <= mem_d[w];
        end
    end

    always_comb begin
        rdata = '1;
        if (32'(idx) < 32'(TOTAL_WORDS)) rdata = mem_q[idx];
    end

endmodule

// File: rtl/isp_flash_ctrl.sv
module isp_flash_ctrl
    import ispf_pkg::*;
#(
    parameter int             APP_BYTES = 1024,
    parameter int             LDR_BYTES = 4096,
    parameter int             CFG_BYTES = 8,
    parameter int             OP_CYCLES = 4,
    parameter int             RA_W      = 5,
    parameter logic [95:0]    UNIQ_ID   = 96'hC3A5_1F00_7E21_9B44_0D6C_E812,
    parameter logic [127:0]   CHIP_ID   = 128'h4455_6677_8899_AABB_CCDD_EEFF_0011_2233,
    parameter logic [31:0]    DEV_ID    = 32'h0002_3B10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            boot_ldr_o
);
    localparam int TOTAL_WORDS = (APP_BYTES + LDR_BYTES + CFG_BYTES) / 4;
    localparam int IDX_W       = $clog2(TOTAL_WORDS);
    localparam int CNT_W       = $clog2(OP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OP_CYCLES - 1);

    typedef struct packed {
        logic             en;
        logic             boot;
        logic             app_we;
        logic             ldr_we;
        logic             cfg_we;
        logic             fail;
        logic [7:0]       cmd;
        logic [31:0]      addr;
        logic [31:0]      data;
        logic [31:0]      vmap;
        logic             go;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    region_e          region;
    logic [IDX_W-1:0] widx;
    logic             word_al, page_al;
    logic             id_hit;
    logic [31:0]      id_word;
    logic [31:0]      arr_rdata;
    logic             prog_d, erase_d;
    logic             done;
    logic             legal;
    logic             upd_ok;
    logic [2:0]       sel;

    // Signals exposed to the bound checker
    logic        go_w, fail_w, en_w, prog_w, erase_w;
    logic [7:0]  cmd_w;
    logic [31:0] addr_w, vmap_w;

    ispf_addr_dec #(
        .APP_BYTES(APP_BYTES),
        .LDR_BYTES(LDR_BYTES),
        .CFG_BYTES(CFG_BYTES),
        .IDX_W    (IDX_W)
    ) u_dec (
        .addr   (st_q.addr),
        .region (region),
        .widx   (widx),
        .word_al(word_al),
        .page_al(page_al)
    );

    ispf_id_rom #(
        .UNIQ_ID(UNIQ_ID),
        .CHIP_ID(CHIP_ID),
        .DEV_ID (DEV_ID)
    ) u_id (
        .op  (st_q.cmd),
        .addr(st_q.addr),
        .hit (id_hit),
        .word(id_word)
    );

    ispf_flash_array #(
        .TOTAL_WORDS(TOTAL_WORDS),
        .IDX_W      (IDX_W)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog_en (prog_d),
        .erase_en(erase_d),
        .idx     (widx),
        .wdata   (st_q.data),
        .rdata   (arr_rdata)
    );

    assign sel  = reg_addr[4:2];
    assign done = st_q.go && (st_q.cnt == CNT_LAST);

    // Region update permission for the current address
    always_comb begin
        case (region)
            RGN_APP: upd_ok = st_q.app_we;
            RGN_LDR: upd_ok = st_q.ldr_we;
            RGN_CFG: upd_ok = st_q.cfg_we;
            default: upd_ok = 1'b0;
        endcase
    end

    // Legality of the pending command, judged at completion
    always_comb begin
        case (st_q.cmd)
            OP_READ:  legal = word_al && (region != RGN_NONE);
            OP_PROG:  legal = word_al && upd_ok;
            OP_ERASE: legal = page_al && upd_ok;
            OP_VMAP:  legal = page_al && (region == RGN_APP || region == RGN_LDR);
            OP_UID, OP_CID, OP_DID: legal = id_hit;
            default:  legal = 1'b0;
        endcase
        if (!st_q.en) legal = 1'b0;
    end

    always_comb begin
        st_d    = st_q;
        prog_d  = 1'b0;
        erase_d = 1'b0;

        if (reg_we) begin
            case (sel)
                RG_CTRL: begin
                    st_d.en     = reg_wdata[CB_EN];
                    st_d.boot   = reg_wdata[CB_BOOT];
                    st_d.app_we = reg_wdata[CB_APPWE];
                    st_d.ldr_we = reg_wdata[CB_LDRWE];
                    st_d.cfg_we = reg_wdata[CB_CFGWE];
                    if (reg_wdata[CB_FAIL]) st_d.fail = 1'b0;
                end
                RG_ADDR: if (!st_q.go) st_d.addr = reg_wdata;
                RG_DATA: if (!st_q.go) st_d.data = reg_wdata;
                RG_CMD:  if (!st_q.go) st_d.cmd  = reg_wdata[7:0];
                RG_TRIG: begin
                    if (!st_q.go && reg_wdata[0]) begin
                        st_d.go  = 1'b1;
                        st_d.cnt = '0;
                    end
                end
                default: ;
            endcase
        end

        if (st_q.go && !done) st_d.cnt = st_q.cnt + CNT_W'(1);

        if (done) begin
            st_d.go = 1'b0;
            if (!legal) begin
                st_d.fail = 1'b1;
            end else begin
                case (st_q.cmd)
                    OP_READ:  st_d.data = arr_rdata;
                    OP_PROG:  prog_d    = 1'b1;
                    OP_ERASE: erase_d   = 1'b1;
                    OP_VMAP:  st_d.vmap = st_q.addr;
                    default:  st_d.data = id_word;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            RG_CTRL: begin
                reg_rdata[CB_EN]    = st_q.en;
                reg_rdata[CB_BOOT]  = st_q.boot;
                reg_rdata[CB_APPWE] = st_q.app_we;
                reg_rdata[CB_LDRWE] = st_q.ldr_we;
                reg_rdata[CB_CFGWE] = st_q.cfg_we;
                reg_rdata[CB_FAIL]  = st_q.fail;
            end
            RG_ADDR: reg_rdata = st_q.addr;
            RG_DATA: reg_rdata = st_q.data;
            RG_CMD:  reg_rdata = {24'd0, st_q.cmd};
            RG_TRIG: reg_rdata = {31'd0, st_q.go};
            RG_STAT: reg_rdata = st_q.vmap;
            default: reg_rdata = '0;
        endcase
    end

    assign boot_ldr_o = st_q.boot;

    assign go_w    = st_q.go;
    assign fail_w  = st_q.fail;
    assign en_w    = st_q.en;
    assign prog_w  = prog_d;
    assign erase_w = erase_d;
    assign cmd_w   = st_q.cmd;
    assign addr_w  = st_q.addr;
    assign vmap_w  = st_q.vmap;

endmodule

// File: rtl/ispf_chk.sv
module ispf_chk #(
    parameter int OP_CYCLES = 4,
    parameter int RA_W      = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_we,
    input logic [RA_W-1:0] reg_addr,
    input logic [31:0]     reg_wdata,
    input logic            go_w,
    input logic            fail_w,
    input logic            en_w,
    input logic            prog_w,
    input logic            erase_w,
    input logic [7:0]      cmd_w,
    input logic [31:0]     addr_w,
    input logic [31:0]     vmap_w
);
    logic [15:0] busy_len;
    logic        fail_clr;

    assign fail_clr = reg_we && (reg_addr[4:2] == 3'd0) && reg_wdata[6];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= '0;
        else if (go_w) busy_len <= busy_len + 16'd1;
        else           busy_len <= '0;
    end

    // R2: trigger never stays set longer than the fixed latency
    a_r2_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        go_w |-> (busy_len < 16'(OP_CYCLES)));

    // R2: trigger clears right after the last busy cycle
    a_r2_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (go_w && busy_len == 16'(OP_CYCLES - 1)) |=> !go_w);

    // R2: command and address are frozen while a command runs
    a_r2_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        go_w |=> ($stable(cmd_w) && $stable(addr_w)));

    // R7: fail flag only drops on an explicit clear write
    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_w && !fail_clr) |=> fail_w);

    // R8: array changes only during a running, enabled command
    a_r8_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_w || erase_w) |-> (go_w && en_w));

    // R8: program and erase never fire together
    a_r8_single_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_w && erase_w));

    // R10: stored remap address is always page aligned
    a_r10_vmap_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        vmap_w[8:0] == 9'd0);

endmodule

bind isp_flash_ctrl ispf_chk #(
    .OP_CYCLES(OP_CYCLES),
    .RA_W     (RA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .go_w     (go_w),
    .fail_w   (fail_w),
    .en_w     (en_w),
    .prog_w   (prog_w),
    .erase_w  (erase_w),
    .cmd_w    (cmd_w),
    .addr_w   (addr_w),
    .vmap_w   (vmap_w)
);

// File: tb/isp_flash_ctrl_tb.sv
module isp_flash_ctrl_tb;

    localparam int           OPC   = 4;
    localparam logic [95:0]  UID_P = 96'hC3A5_1F00_7E21_9B44_0D6C_E812;
    localparam logic [127:0] CHP_P = 128'h4455_6677_8899_AABB_CCDD_EEFF_0011_2233;
    localparam logic [31:0]  DID_P = 32'h0002_3B10;

    localparam logic [4:0] A_CTRL = 5'h00, A_ADDR = 5'h04, A_DATA = 5'h08,
                           A_CMD  = 5'h0C, A_TRIG = 5'h10, A_STAT = 5'h14;
    localparam logic [31:0] ALL_ON = 32'h0000_0039; // enable + 3 region enables
    localparam logic [31:0] FAILB  = 32'h0000_0040;

    typedef struct packed {
        logic [7:0]  op;
        logic [31:0] a;
        logic [31:0] wd;
        logic        ef;
        logic        cd;
        logic [31:0] ed;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{8'h00, 32'h0000_0000, 32'h0,          1'b0, 1'b1, 32'hFFFF_FFFF},
        '{8'h21, 32'h0000_0000, 32'h1234_5678,  1'b0, 1'b0, 32'h0},
        '{8'h00, 32'h0000_0000, 32'h0,          1'b0, 1'b1, 32'h1234_5678},
        '{8'h21, 32'h0000_0000, 32'hFF00_FF00,  1'b0, 1'b0, 32'h0},
        '{8'h00, 32'h0000_0000, 32'h0,          1'b0, 1'b1, 32'h1200_5600},
        '{8'h21, 32'h0010_0004, 32'hA5A5_A5A5,  1'b0, 1'b0, 32'h0},
        '{8'h00, 32'h0010_0004, 32'h0,          1'b0, 1'b1, 32'hA5A5_A5A5},
        '{8'h0B, 32'h0000_0000, 32'h0,          1'b0, 1'b1, 32'h0000_00DA},
        '{8'h04, 32'h0000_0004, 32'h0,          1'b0, 1'b1, 32'h7E21_9B44},
        '{8'h0C, 32'h0000_0004, 32'h0,          1'b0, 1'b1, 32'h0002_3B10},
        '{8'h00, 32'h0000_0002, 32'h0,          1'b1, 1'b0, 32'h0},
        '{8'h21, 32'h0000_0400, 32'h0,          1'b1, 1'b0, 32'h0},
        '{8'h22, 32'h0000_0100, 32'h0,          1'b1, 1'b0, 32'h0},
        '{8'h33, 32'h0000_0000, 32'h0,          1'b1, 1'b0, 32'h0},
        '{8'h22, 32'h0000_0000, 32'h0,          1'b0, 1'b0, 32'h0},
        '{8'h00, 32'h0000_0000, 32'h0,          1'b0, 1'b1, 32'hFFFF_FFFF},
        '{8'h00, 32'h0010_0004, 32'h0,          1'b0, 1'b1, 32'hA5A5_A5A5},
        '{8'h21, 32'h0030_0000, 32'h0F0F_0F0F,  1'b0, 1'b0, 32'h0},
        '{8'h00, 32'h0030_0000, 32'h0,          1'b0, 1'b1, 32'h0F0F_0F0F},
        '{8'h04, 32'h0000_000C, 32'h0,          1'b1, 1'b0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        boot_ldr_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    isp_flash_ctrl #(
        .OP_CYCLES(OPC),
        .UNIQ_ID  (UID_P),
        .CHIP_ID  (CHP_P),
        .DEV_ID   (DID_P)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .boot_ldr_o(boot_ldr_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp=<100000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic run(input logic [7:0] op, input logic [31:0] a,
                       input logic [31:0] d, output int blen);
        logic [31:0] t;
        wr(A_CMD, {24'd0, op});
        wr(A_ADDR, a);
        wr(A_DATA, d);
        wr(A_TRIG, 32'd1);
        blen = 0;
        rd(A_TRIG, t);
        while (t[0] && blen < 1000) begin
            blen++;
            @(posedge clk);
            #1;
            rd(A_TRIG, t);
        end
    endtask

    function automatic string tag_of(input logic [7:0] op, input logic ef);
        if (ef) return "R8";
        case (op)
            8'h21:                return "R4";
            8'h22:                return "R5";
            8'h04, 8'h0B, 8'h0C:  return "R9";
            default:              return "R3";
        endcase
    endfunction

    initial begin
        logic [31:0] v;
        int bl;

        repeat (3) @(posedge clk);
        #1;
        // R1: reset state of every register and the boot pin
        rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        rd(A_ADDR, v); check("R1 addr", v, 32'h0);
        rd(A_DATA, v); check("R1 data", v, 32'h0);
        rd(A_CMD,  v); check("R1 cmd", v, 32'h0);
        rd(A_TRIG, v); check("R1 trig", v, 32'h0);
        rd(A_STAT, v); check("R1 status", v, 32'h0);
        check("R1 boot pin", {31'd0, boot_ldr_o}, 32'h0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R2: trigger write with bit 0 clear starts nothing
        wr(A_TRIG, 32'h2);
        rd(A_TRIG, v); check("R2 no start", v, 32'h0);

        // Table walk (R1 erased read in row 0)
        for (int i = 0; i < NV; i++) begin
            wr(A_CTRL, ALL_ON | FAILB);
            run(TBL[i].op, TBL[i].a, TBL[i].wd, bl);
            if (i == 0) check("R2 busy length", bl, OPC);
            rd(A_CTRL, v);
            check({tag_of(TBL[i].op, TBL[i].ef), " fail flag"}, {31'd0, v[6]}, {31'd0, TBL[i].ef});
            if (TBL[i].cd) begin
                rd(A_DATA, v);
                check({tag_of(TBL[i].op, TBL[i].ef), " data"}, v, TBL[i].ed);
            end
        end

        // R9: chip-ID word 0 at offset 0x10, unique word 2 at 0x8
        wr(A_CTRL, ALL_ON | FAILB);
        run(8'h04, 32'h10, 32'h0, bl);
        rd(A_DATA, v); check("R9 chip word0", v, CHP_P[31:0]);
        run(8'h04, 32'h8, 32'h0, bl);
        rd(A_DATA, v); check("R9 uid word2", v, UID_P[95:64]);
        run(8'h0B, 32'h4, 32'h0, bl);
        rd(A_CTRL, v); check("R9 cid bad addr", {31'd0, v[6]}, 32'h1);

        // R8: master enable clear -> fail, word untouched
        wr(A_CTRL, 32'h38 | FAILB);
        run(8'h21, 32'h8, 32'h0, bl);
        rd(A_CTRL, v); check("R8 disabled fail", {31'd0, v[6]}, 32'h1);
        wr(A_CTRL, ALL_ON | FAILB);
        run(8'h00, 32'h8, 32'h0, bl);
        rd(A_DATA, v); check("R8 disabled untouched", v, 32'hFFFF_FFFF);

        // R6: application update disabled
        wr(A_CTRL, 32'h31 | FAILB);
        run(8'h21, 32'h10, 32'h0, bl);
        rd(A_CTRL, v); check("R6 app protect fail", {31'd0, v[6]}, 32'h1);
        run(8'h00, 32'h10, 32'h0, bl);
        rd(A_DATA, v); check("R6 app untouched", v, 32'hFFFF_FFFF);
        // R7: fail still set after a successful read
        rd(A_CTRL, v); check("R7 sticky", {31'd0, v[6]}, 32'h1);
        wr(A_CTRL, 32'h31 | FAILB);
        rd(A_CTRL, v); check("R7 w1c", {31'd0, v[6]}, 32'h0);

        // R6: loader update disabled, erase rejected
        wr(A_CTRL, 32'h29 | FAILB);
        run(8'h22, 32'h0010_0000, 32'h0, bl);
        rd(A_CTRL, v); check("R6 ldr protect fail", {31'd0, v[6]}, 32'h1);
        run(8'h00, 32'h0010_0004, 32'h0, bl);
        rd(A_DATA, v); check("R6 ldr untouched", v, 32'hA5A5_A5A5);

        // R6: config update disabled
        wr(A_CTRL, 32'h19 | FAILB);
        run(8'h21, 32'h0030_0000, 32'h0, bl);
        run(8'h00, 32'h0030_0000, 32'h0, bl);
        rd(A_DATA, v); check("R6 cfg untouched", v, 32'h0F0F_0F0F);

        // R2: writes during a running command are ignored
        wr(A_CTRL, ALL_ON | FAILB);
        wr(A_CMD, 32'h00);
        wr(A_ADDR, 32'h0010_0004);
        wr(A_TRIG, 32'h1);
        wr(A_ADDR, 32'h0000_0000);
        wr(A_CMD, 32'h21);
        repeat (OPC) @(posedge clk);
        #1;
        rd(A_TRIG, v); check("R2 cleared", v, 32'h0);
        rd(A_ADDR, v); check("R2 addr held", v, 32'h0010_0004);
        rd(A_CMD,  v); check("R2 cmd held", v, 32'h0);
        rd(A_DATA, v); check("R2 result", v, 32'hA5A5_A5A5);

        // R10: vector map
        run(8'h2E, 32'h0010_0200, 32'h0, bl);
        rd(A_STAT, v); check("R10 vmap", v, 32'h0010_0200);
        run(8'h2E, 32'h0010_0010, 32'h0, bl);
        rd(A_CTRL, v); check("R10 misaligned fail", {31'd0, v[6]}, 32'h1);
        rd(A_STAT, v); check("R10 vmap kept", v, 32'h0010_0200);

        // R11: boot select
        wr(A_CTRL, 32'h2);
        check("R11 boot pin", {31'd0, boot_ldr_o}, 32'h1);
        rd(A_CTRL, v); check("R11 readback", v & 32'h2, 32'h2);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule